// File: doc/BRIEF.md
# Bus Controller Word Transmitter

This block is the transmit side of a bus controller on a command/response serial data bus. It carries out one controller-to-terminal transfer at a time. A start pulse is accepted while the block is idle. The block then builds a command word from the terminal address, the subaddress and the word count, and sends it on a single Manchester-encoded line at 1 Mbit/s. The data words follow the command word with no gap. After the last data word the block waits for a status acknowledgement from the addressed terminal before it accepts another start.

Each word takes 20 bit times. It begins with a three-bit-time sync pattern whose polarity tells command words from data words, then carries 16 Manchester-coded bits with the most significant bit first, and ends with an odd-parity bit. A half-bit tick divided from the system clock (25 clocks by default, which gives a 2 MHz tick from 50 MHz) sets the timing. One half-bit counter paces every word format. The block reads data words one at a time through an index output, so the surrounding logic keeps the payload in its own storage. When a receiver reports a status word, the transfer completes. When no status word comes within a configurable number of clocks, the transfer completes with a no-response flag.

Top module: `bc_word_transmitter`

## Requirements
- R1: After reset the line is low and busy, done and noResp are all low.
- R2: The command word carries rtAddr in bits 15..11, a receive-direction bit of 0 in bit 10, subAddr in bits 9..5 and wordCnt in bits 4..0. The block captures these inputs in the cycle that accepts start.
- R3: A command word begins with 3 half-bit periods high followed by 3 low. A data word begins with 3 half-bit periods low followed by 3 high.
- R4: After the sync come the 16 word bits, most significant bit first. A 1 is sent as high then low, a 0 as low then high. Each half-bit lasts TICK_DIV clocks, and half-bit k of a transfer is driven from k*TICK_DIV clocks after the edge that accepts start.
- R5: The 20th bit time carries a parity bit chosen so that the 16 word bits plus the parity bit hold an odd number of ones. It is Manchester-coded in the same way as a data bit.
- R6: The data words follow the command word with no idle half-bit between any two words. A wordCnt of 1..31 sends that many data words, and 0 sends 32. Data word i is taken from dataWord while dataIdx equals i.
- R7: The line is low whenever no word is being sent. busy is high from the edge that accepts start until the edge that raises done.
- R8: While the block waits for the acknowledgement, a statusRcvd pulse ends the transfer. done is high for exactly one cycle, busy drops in the same cycle, and noResp is 0.
- R9: If statusRcvd stays low for RESP_TIMEOUT clocks after the last word ends, done pulses with noResp set to 1. noResp holds until the next start is accepted, which clears it.
- R10: A start pulse while busy is ignored and does not change the words being sent. A statusRcvd pulse before the last word has ended is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a transfer; accepted only when idle |
| rtAddr | input | 5 | Terminal address for the command word |
| subAddr | input | 5 | Subaddress for the command word |
| wordCnt | input | 5 | Number of data words; 0 means 32 |
| dataWord | input | 16 | Data word selected by dataIdx |
| dataIdx | output | 5 | Index of the data word to present on dataWord |
| statusRcvd | input | 1 | Pulse from the receiver when the terminal's status word arrives |
| lineOut | output | 1 | Manchester-encoded serial line, low when idle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer completes |
| noResp | output | 1 | The last transfer ended without a status word |

## Verification
The line changes level only at half-bit boundaries, and half-bit k starts k*TICK_DIV clocks after the accepting edge. The bench therefore reads each half-bit at the falling edge that falls inside the first clock of its period, so no sample lands on a boundary. The words run back to back, so the wait for the status word begins exactly (1+N)*40*TICK_DIV clocks after the accepting edge, and the bench checks the idle line and busy at that point. done is registered: it is checked at the falling edge after the clock that samples statusRcvd, and, in the timeout case, at RESP_TIMEOUT clocks into the wait, with the cycle before it checked to still show busy and no done.

// File: rtl/bcx_pkg.sv
package bcx_pkg;

  // Control-to-datapath strobes: start a command word or a data word
  typedef struct packed {
    logic loadCmd;
    logic loadData;
  } txStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } txnState_t;

  localparam int HALF_BITS_PER_WORD = 40;
  localparam int SYNC_HALF_BITS     = 3;

endpackage

// File: rtl/bcx_word_serializer.sv
module bcx_word_serializer
  import bcx_pkg::*;
#(
  parameter int TICK_DIV = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  txStrobe_t   strobe,
  input  logic [15:0] cmdWord,
  input  logic [15:0] dataWord,
  output logic        lineOut,
  output logic        wordEnd
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int HB_W  = $clog2(HALF_BITS_PER_WORD);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [HB_W-1:0]  HB_LAST  = HB_W'(HALF_BITS_PER_WORD - 1);
  localparam logic [HB_W-1:0]  SYNC_A   = HB_W'(SYNC_HALF_BITS);
  localparam logic [HB_W-1:0]  SYNC_B   = HB_W'(2 * SYNC_HALF_BITS);

  logic             active;
  logic             isCmd;
  logic [15:0]      word;
  logic [HB_W-1:0]  halfCnt;
  logic [DIV_W-1:0] divCnt;
  logic             tickEnd;
  logic [HB_W-1:0]  rel;
  logic             parityBit;
  logic             bitVal;
  logic             level;

  assign tickEnd = (divCnt == DIV_LAST);
  assign wordEnd = active && tickEnd && (halfCnt == HB_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      isCmd   <= 1'b0;
      word    <= '0;
      halfCnt <= '0;
      divCnt  <= '0;
    end else if (strobe.loadCmd || strobe.loadData) begin
      active  <= 1'b1;
      isCmd   <= strobe.loadCmd;
      word    <= strobe.loadCmd ? cmdWord : dataWord;
      halfCnt <= '0;
      divCnt  <= '0;
    end else if (active) begin
      if (tickEnd) begin
        divCnt <= '0;
        if (halfCnt == HB_LAST) begin
          active  <= 1'b0;
          halfCnt <= '0;
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // Half-bit decode: sync, 16 Manchester bits, then parity
  always_comb begin
    rel       = halfCnt - SYNC_B;
    parityBit = ~(^word);
    bitVal    = rel[5] ? parityBit : word[~rel[4:1]];
    if (halfCnt < SYNC_A)      level = isCmd;
    else if (halfCnt < SYNC_B) level = ~isCmd;
    else                       level = bitVal ^ rel[0];
  end

  assign lineOut = active & level;

endmodule

// File: rtl/bcx_txn_control.sv
module bcx_txn_control
  import bcx_pkg::*;
#(
  parameter int RESP_TIMEOUT = 700
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       statusRcvd,
  input  logic [4:0] wordCnt,
  input  logic       wordEnd,
  output txStrobe_t  strobe,
  output logic [4:0] dataIdx,
  output logic       busy,
  output logic       done,
  output logic       noResp
);

  localparam int TMR_W = $clog2(RESP_TIMEOUT + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(RESP_TIMEOUT - 1);

  txnState_t        state;
  logic [5:0]       wordsLeft;
  logic [TMR_W-1:0] timer;

  always_comb begin
    strobe.loadCmd  = (state == ST_IDLE) && start;
    strobe.loadData = (state == ST_SEND) && wordEnd && (wordsLeft != 6'd0);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wordsLeft <= '0;
      dataIdx   <= '0;
      timer     <= '0;
      done      <= 1'b0;
      noResp    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_SEND;
            wordsLeft <= (wordCnt == 5'd0) ? 6'd32 : {1'b0, wordCnt};
            dataIdx   <= '0;
            noResp    <= 1'b0;
          end
        end
        ST_SEND: begin
          if (wordEnd) begin
            if (wordsLeft != 6'd0) begin
              wordsLeft <= wordsLeft - 1'b1;
              dataIdx   <= dataIdx + 1'b1;
            end else begin
              state <= ST_WAIT;
              timer <= '0;
            end
          end
        end
        ST_WAIT: begin
          if (statusRcvd) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (timer == TMR_LAST) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            noResp <= 1'b1;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bc_word_transmitter.sv
module bc_word_transmitter
  import bcx_pkg::*;
#(
  parameter int TICK_DIV     = 25,
  parameter int RESP_TIMEOUT = 700
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [4:0]  rtAddr,
  input  logic [4:0]  subAddr,
  input  logic [4:0]  wordCnt,
  input  logic [15:0] dataWord,
  output logic [4:0]  dataIdx,
  input  logic        statusRcvd,
  output logic        lineOut,
  output logic        busy,
  output logic        done,
  output logic        noResp
);

  txStrobe_t   strobe;
  logic        wordEnd;
  logic [15:0] cmdWord;

  // Direction bit 0: terminal receives
  assign cmdWord = {rtAddr, 1'b0, subAddr, wordCnt};

  bcx_txn_control #(.RESP_TIMEOUT(RESP_TIMEOUT)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .statusRcvd (statusRcvd),
    .wordCnt    (wordCnt),
    .wordEnd    (wordEnd),
    .strobe     (strobe),
    .dataIdx    (dataIdx),
    .busy       (busy),
    .done       (done),
    .noResp     (noResp)
  );

  bcx_word_serializer #(.TICK_DIV(TICK_DIV)) i_ser (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdWord  (cmdWord),
    .dataWord (dataWord),
    .lineOut  (lineOut),
    .wordEnd  (wordEnd)
  );

endmodule

// File: rtl/bcx_checker.sv
module bcx_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic statusRcvd,
  input logic lineOut,
  input logic busy,
  input logic done,
  input logic noResp
);

  a_r7_line_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineOut);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r9_noresp_rises_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(noResp) |-> done);

  a_r10_start_keeps_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !statusRcvd) |=> busy || done);

endmodule

bind bc_word_transmitter bcx_checker i_bcx_checker (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .statusRcvd (statusRcvd),
  .lineOut    (lineOut),
  .busy       (busy),
  .done       (done),
  .noResp     (noResp)
);

// File: tb/test_bc_word_transmitter.sv
module test_bc_word_transmitter;

  localparam int TICK_DIV = 4;
  localparam int TIMEOUT  = 50;
  localparam int NVEC     = 5;

  // Vector: rt(5) sa(5) wc(5) seed(16) mode(2) delay(8)
  // mode 0: respond, 1: no response, 2: respond with stray start/status during command
  localparam logic [40:0] VEC [NVEC] = '{
    {5'h05, 5'h0A, 5'd2,  16'h4142, 2'd0, 8'd3},
    {5'h1F, 5'h01, 5'd1,  16'hFFFF, 2'd2, 8'd0},
    {5'h00, 5'h1F, 5'd0,  16'h0000, 2'd0, 8'd5},
    {5'h12, 5'h0C, 5'd3,  16'hA5A5, 2'd1, 8'd0},
    {5'h0A, 5'h15, 5'd1,  16'h8001, 2'd0, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  rtAddr = '0;
  logic [4:0]  subAddr = '0;
  logic [4:0]  wordCnt = '0;
  logic [15:0] dataWord;
  logic [4:0]  dataIdx;
  logic        statusRcvd = 1'b0;
  logic        lineOut, busy, done, noResp;
  logic [15:0] curData [32];

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always_comb dataWord = curData[dataIdx];

  bc_word_transmitter #(.TICK_DIV(TICK_DIV), .RESP_TIMEOUT(TIMEOUT)) i_bc_word_transmitter (
    .clk(clk), .rstN(rstN), .start(start), .rtAddr(rtAddr), .subAddr(subAddr),
    .wordCnt(wordCnt), .dataWord(dataWord), .dataIdx(dataIdx),
    .statusRcvd(statusRcvd), .lineOut(lineOut), .busy(busy), .done(done), .noResp(noResp)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // Expected half-bit levels of one word, index = half-bit number
  function automatic logic [39:0] expWord(input logic [15:0] w, input logic cmd);
    logic [39:0] e;
    logic p;
    for (int i = 0; i < 3; i++) begin
      e[i]   = cmd;
      e[i+3] = ~cmd;
    end
    for (int b = 0; b < 16; b++) begin
      e[6+2*b] = w[15-b];
      e[7+2*b] = ~w[15-b];
    end
    p = 1'b1;
    for (int b = 0; b < 16; b++) p = p ^ w[b];
    e[38] = p;
    e[39] = ~p;
    return e;
  endfunction

  // Sample one word, one falling edge inside each half-bit period
  task automatic sampleWord(input logic [15:0] w, input logic cmd, input bit glitch,
                            input string req, input int vi, input int wi);
    logic [39:0] got;
    logic [39:0] exp;
    exp = expWord(w, cmd);
    for (int k = 0; k < 40; k++) begin
      got[k] = lineOut;
      if (glitch && k == 10) begin
        start = 1'b1;
        rtAddr = ~rtAddr;
      end
      if (glitch && k == 11) start = 1'b0;
      if (glitch && k == 20) statusRcvd = 1'b1;
      if (glitch && k == 21) statusRcvd = 1'b0;
      repeat (TICK_DIV) @(negedge clk);
    end
    check(got == exp, $sformatf("%s vec %0d word %0d", req, vi, wi), 64'(got), 64'(exp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check(lineOut == 1'b0 && busy == 1'b0 && done == 1'b0 && noResp == 1'b0,
          "R1 reset idle", 64'({lineOut, busy, done, noResp}), 64'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(lineOut == 1'b0 && busy == 1'b0, "R1 idle after reset", 64'({lineOut, busy}), 64'(0));

    for (int v = 0; v < NVEC; v++) begin
      logic [4:0]  rt, sa, wc;
      logic [15:0] seed;
      logic [1:0]  mode;
      logic [7:0]  dly;
      logic [15:0] cmdExp;
      int n;
      {rt, sa, wc, seed, mode, dly} = VEC[v];
      n = (wc == 5'd0) ? 32 : int'(wc);
      for (int i = 0; i < 32; i++) curData[i] = seed ^ (16'(i) * 16'h2469);
      rtAddr = rt; subAddr = sa; wordCnt = wc;
      cmdExp = {rt, 1'b0, sa, wc};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R9 noResp cleared on accepted start; R7 busy raised
      check(busy == 1'b1 && noResp == 1'b0, "R7/R9 busy set, noResp cleared",
            64'({busy, noResp}), 64'(2));
      // R2 R3 R4 R5 R10 command word
      sampleWord(cmdExp, 1'b1, mode == 2'd2, "R2/R3/R4/R5/R10 command", v, 0);
      rtAddr = rt;
      for (int d = 0; d < n; d++)
        sampleWord(curData[d], 1'b0, 1'b0, "R3/R4/R5/R6 data", v, d + 1);
      // R7 R10: line idle and still waiting after last word
      check(lineOut == 1'b0 && busy == 1'b1 && done == 1'b0, "R7/R10 waiting after last word",
            64'({lineOut, busy, done}), 64'(2));
      if (mode == 2'd1) begin
        repeat (TIMEOUT - 1) @(negedge clk);
        check(busy == 1'b1 && done == 1'b0, "R9 before timeout", 64'({busy, done}), 64'(2));
        @(negedge clk);
        check(done == 1'b1 && noResp == 1'b1 && busy == 1'b0, "R9 timeout done",
              64'({done, noResp, busy}), 64'(6));
        @(negedge clk);
        check(done == 1'b0 && noResp == 1'b1, "R9 noResp held", 64'({done, noResp}), 64'(1));
      end else begin
        repeat (int'(dly)) @(negedge clk);
        statusRcvd = 1'b1;
        @(negedge clk);
        statusRcvd = 1'b0;
        check(done == 1'b1 && noResp == 1'b0 && busy == 1'b0, "R8 status done",
              64'({done, noResp, busy}), 64'(4));
        @(negedge clk);
        check(done == 1'b0 && lineOut == 1'b0, "R8 done single cycle", 64'({done, lineOut}), 64'(0));
      end
      repeat (3) @(negedge clk);
    end

    // R10: stray status while idle has no effect
    statusRcvd = 1'b1;
    @(negedge clk);
    statusRcvd = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && lineOut == 1'b0, "R10 idle status ignored",
          64'({busy, done, lineOut}), 64'(0));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule